// File: doc/BRIEF.md
# Synchronous CPU bus interface unit

This block connects the execution logic of an 8-bit processor to external memory over a fully synchronous bus in which each access takes one clock. In every cycle the core may present a request made of an address, a direction, write data and a flag that marks an opcode fetch. The unit registers that request onto the bus pins, so every bus output changes only at a rising clock edge.

The data path is split into an input bus and an output bus. An active-high output enable is provided so that tri-state buffers outside the block can build a bidirectional bus from it. Read data arriving on the input bus is sampled one edge after the read strobe rises. It is then handed back to the core together with a single-cycle valid pulse. Requests may arrive on consecutive cycles, and each one becomes a bus cycle with no idle cycle in between.

Top module: `cpu_bus_unit`

## Requirements
- R1: While rst_ni is low, bus_rd_o, bus_wr_o, bus_oe_o, bus_sync_o and rsp_valid_o are 0, and bus_addr_o, bus_dout_o and rsp_data_o are all zeros.
- R2: A request with req_valid_i=1 and req_we_i=0 that is sampled at a rising edge makes bus_rd_o=1, bus_wr_o=0 and bus_addr_o=req_addr_i in the cycle that follows that edge.
- R3: A request with req_valid_i=1 and req_we_i=1 that is sampled at a rising edge makes bus_wr_o=1, bus_rd_o=0, bus_addr_o=req_addr_i and bus_dout_o=req_wdata_i in the cycle that follows.
- R4: bus_oe_o is 1 exactly in write cycles. Whenever bus_oe_o is 0, bus_dout_o is all zeros.
- R5: A cycle with req_valid_i=0 gives bus_rd_o, bus_wr_o, bus_oe_o and bus_sync_o all 0 in the following cycle. bus_addr_o keeps the last address that was driven.
- R6: bus_sync_o is 1 only in a read cycle whose request had req_fetch_i=1. On a write, req_fetch_i has no effect.
- R7: rsp_valid_o is 1 for exactly the one cycle after each cycle in which bus_rd_o was 1. In that cycle rsp_data_o equals bus_din_i as sampled at the rising edge that ends the read cycle.
- R8: Requests on consecutive cycles produce bus cycles on consecutive cycles, in any mix of reads and writes, with no idle cycle inserted.
- R9: When rsp_valid_o is 0, rsp_data_o keeps the last captured read value.
- R10: bus_rd_o and bus_wr_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all outputs change on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core requests a bus cycle this clock |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | Request is the first byte of an instruction fetch |
| req_addr_i | input | ADDR_W (16) | Request address |
| req_wdata_i | input | DATA_W (8) | Write data |
| bus_addr_o | output | ADDR_W (16) | Registered bus address |
| bus_rd_o | output | 1 | Read strobe, active high |
| bus_wr_o | output | 1 | Write strobe, active high |
| bus_dout_o | output | DATA_W (8) | Output data bus |
| bus_oe_o | output | 1 | Output enable for external buffers, active high |
| bus_sync_o | output | 1 | Opcode fetch marker |
| bus_din_i | input | DATA_W (8) | Input data bus |
| rsp_valid_o | output | 1 | One-cycle pulse: read data is available |
| rsp_data_o | output | DATA_W (8) | Captured read data |

## Verification
The bench builds the unit with its default widths: a 16-bit address and 8-bit data. At these widths a random address or data value seldom repeats the one before it. A stale address, a data value held over from an earlier cycle, or a response paired with the wrong cycle of input data therefore shows up as a mismatch. Random mixes of reads, writes and idle cycles reach back-to-back direction changes and fetch flags on writes. Directed sequences cover reset, hold during idle cycles, and read-write-read runs.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic sync;
  } bus_ctl_t;

  localparam bus_ctl_t CTL_IDLE = '{rd: 1'b0, wr: 1'b0, sync: 1'b0};
endpackage

// File: rtl/cbu_req_decode.sv
module cbu_req_decode
  import cbu_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              valid_i,
  input  logic              we_i,
  input  logic              fetch_i,
  input  logic [DATA_W-1:0] wdata_i,
  output bus_ctl_t          ctl_o,
  output logic              load_addr_o,
  output logic [DATA_W-1:0] dout_o
);
  always_comb begin
    ctl_o       = CTL_IDLE;
    load_addr_o = valid_i;
    dout_o      = '0;
    if (valid_i) begin
      ctl_o.rd   = ~we_i;
      ctl_o.wr   = we_i;
      // fetch marker only meaningful on reads
      ctl_o.sync = fetch_i & ~we_i;
      if (we_i) dout_o = wdata_i;
    end
  end
endmodule

// File: rtl/cbu_bus_drv.sv
module cbu_bus_drv
  import cbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ctl_t          ctl_i,
  input  logic              load_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dout_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              oe_o,
  output logic              sync_o,
  output logic [DATA_W-1:0] dout_o
);
  bus_ctl_t ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_IDLE;
      oe_o   <= 1'b0;
      dout_o <= '0;
    end else begin
      ctl_q  <= ctl_i;
      oe_o   <= ctl_i.wr;
      dout_o <= dout_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          addr_o <= '0;
    else if (load_addr_i) addr_o <= addr_i;
  end

  assign rd_o   = ctl_q.rd;
  assign wr_o   = ctl_q.wr;
  assign sync_o = ctl_q.sync;

  assert_strobe_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));
  assert_oe_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o |-> wr_o);
  assert_dout_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (dout_o == '0));
  assert_sync_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> rd_o);
  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_addr_i |=> (!rd_o && !wr_o && $stable(addr_o)));
endmodule

// File: rtl/cbu_rd_capture.sv
module cbu_rd_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= rd_i;
      if (rd_i) data_o <= din_i;
    end
  end

  assert_pulse_after_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> valid_o);
  assert_data_sampled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (data_o == $past(din_i)));
  assert_data_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(data_o));
endmodule

// File: rtl/cpu_bus_unit.sv
module cpu_bus_unit
  import cbu_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic              req_fetch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_oe_o,
  output logic              bus_sync_o,
  input  logic [DATA_W-1:0] bus_din_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  bus_ctl_t          ctl_d;
  logic              load_addr;
  logic [DATA_W-1:0] dout_d;

  cbu_req_decode #(.DATA_W(DATA_W)) u_dec (
    .valid_i     (req_valid_i),
    .we_i        (req_we_i),
    .fetch_i     (req_fetch_i),
    .wdata_i     (req_wdata_i),
    .ctl_o       (ctl_d),
    .load_addr_o (load_addr),
    .dout_o      (dout_d)
  );

  cbu_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctl_i       (ctl_d),
    .load_addr_i (load_addr),
    .addr_i      (req_addr_i),
    .dout_i      (dout_d),
    .addr_o      (bus_addr_o),
    .rd_o        (bus_rd_o),
    .wr_o        (bus_wr_o),
    .oe_o        (bus_oe_o),
    .sync_o      (bus_sync_o),
    .dout_o      (bus_dout_o)
  );

  cbu_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (bus_rd_o),
    .din_i   (bus_din_i),
    .valid_o (rsp_valid_o),
    .data_o  (rsp_data_o)
  );

  // back-to-back: a request always yields a strobe next cycle
  assert_no_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (bus_rd_o || bus_wr_o));
  assert_write_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i) |=> (bus_dout_o == $past(req_wdata_i)));
  assert_read_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> (bus_rd_o && bus_addr_o == $past(req_addr_i)));
endmodule

// File: tb/cpu_bus_unit_test.sv
`timescale 1ns/1ps
module cpu_bus_unit_test;
  localparam int AW = 16;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          rst_ni;
  logic          req_valid_i, req_we_i, req_fetch_i;
  logic [AW-1:0] req_addr_i;
  logic [DW-1:0] req_wdata_i, bus_din_i;
  logic [AW-1:0] bus_addr_o;
  logic          bus_rd_o, bus_wr_o, bus_oe_o, bus_sync_o, rsp_valid_o;
  logic [DW-1:0] bus_dout_o, rsp_data_o;

  cpu_bus_unit uut (.*);

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic [AW-1:0] m_addr = '0;
  logic          m_rd = 0, m_wr = 0, m_sync = 0, m_rv = 0;
  logic [DW-1:0] m_dout = '0, m_rdata = '0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_rd(logic v, logic we);
    return v && !we;
  endfunction
  function automatic logic exp_sync(logic v, logic we, logic f);
    return v && !we && f;
  endfunction
  function automatic logic [DW-1:0] exp_dout(logic v, logic we, logic [DW-1:0] wd);
    return (v && we) ? wd : '0;
  endfunction

  task automatic check_all(logic v, logic we);
    string t_rd, t_wr;
    t_rd = !v ? "R5" : "R2";
    t_wr = !v ? "R5" : "R3";
    chk(t_rd, "bus_addr_o", bus_addr_o, m_addr);
    chk(t_rd, "bus_rd_o", bus_rd_o, m_rd);
    chk(t_wr, "bus_wr_o", bus_wr_o, m_wr);
    chk("R3", "bus_dout_o", bus_dout_o, m_dout);
    chk("R4", "bus_oe_o", bus_oe_o, m_wr);
    chk("R6", "bus_sync_o", bus_sync_o, m_sync);
    chk("R7", "rsp_valid_o", rsp_valid_o, m_rv);
    chk("R9", "rsp_data_o", rsp_data_o, m_rdata);
    chk("R10", "strobe overlap", bus_rd_o & bus_wr_o, 0);
  endtask

  // called at a negedge; returns at the next negedge after checking
  task automatic step(logic v, logic we, logic f, logic [AW-1:0] a,
                      logic [DW-1:0] wd, logic [DW-1:0] din);
    req_valid_i = v; req_we_i = we; req_fetch_i = f;
    req_addr_i = a; req_wdata_i = wd; bus_din_i = din;
    @(posedge clk_i);
    m_rv = m_rd;
    if (m_rd) m_rdata = din;
    if (v) m_addr = a;
    m_rd   = exp_rd(v, we);
    m_wr   = v && we;
    m_sync = exp_sync(v, we, f);
    m_dout = exp_dout(v, we, wd);
    @(negedge clk_i);
    check_all(v, we);
  endtask

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_ni = 0; req_valid_i = 0; req_we_i = 0; req_fetch_i = 0;
    req_addr_i = '0; req_wdata_i = '0; bus_din_i = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "bus_rd_o", bus_rd_o, 0);
    chk("R1", "bus_wr_o", bus_wr_o, 0);
    chk("R1", "bus_oe_o", bus_oe_o, 0);
    chk("R1", "bus_sync_o", bus_sync_o, 0);
    chk("R1", "rsp_valid_o", rsp_valid_o, 0);
    chk("R1", "bus_addr_o", bus_addr_o, 0);
    chk("R1", "bus_dout_o", bus_dout_o, 0);
    chk("R1", "rsp_data_o", rsp_data_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R6 fetch read, then fetch flag on write ignored
    step(1, 0, 1, 16'h0200, 8'h00, 8'h11);
    step(1, 1, 1, 16'h0300, 8'hA5, 8'hEA);
    // R5 idle cycles hold the address
    step(0, 0, 0, 16'hFFFF, 8'h77, 8'h33);
    step(0, 1, 1, 16'h1234, 8'h55, 8'h44);
    // R8 back-to-back read, write, read, read
    step(1, 0, 0, 16'h8000, 8'h00, 8'h00);
    step(1, 1, 0, 16'h8001, 8'h5A, 8'hC3);
    step(1, 0, 1, 16'h8002, 8'h00, 8'h99);
    step(1, 0, 0, 16'hFFFF, 8'h00, 8'h3C);
    step(0, 0, 0, 16'h0000, 8'h00, 8'h81);
    step(0, 0, 0, 16'h0000, 8'h00, 8'h18);

    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom), DW'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule